// File: doc/BRIEF.md
# Memory-Mapped Lite Serial Controller

The block is a compact asynchronous serial port that sits on a 32-bit register bus. Software reaches it through a window of four word registers: a port that pops received bytes, a port that queues bytes for sending, a status word and a write-only control word. Characters to send wait in a transmit queue and leave as frames of one start bit, eight data bits (least significant first) and one stop bit. Incoming frames are rebuilt by a receiver that oversamples the line sixteen times per bit and takes each bit at its middle, and finished bytes wait in a receive queue.

The bit rate is set at elaboration by the number of clocks per oversample tick, so one bit lasts 16 x OVS_DIV clocks. The status word combines queue state, an echo of the interrupt enable and sticky receive errors that clear when the status word is read. The interrupt line gives one-clock pulses for a receiver that has just gained data and for a transmit queue that the serializer has just drained, and is meant to be caught on its rising edge.

Top module: `lu_uart`

## Requirements
- R1: After reset the status word reads 0x04 (only bit2, transmit queue empty, set), irq is low and txd is high.
- R2: A write to word 1 queues busWdata[7:0]; the byte leaves on txd as a low start bit, eight data bits least significant first and a high stop bit, each 16 x OVS_DIV clocks long, with txd high between frames.
- R3: The transmit queue holds DEPTH (16) bytes besides the one in the serializer; status bit3 reads 1 when it is full, and a write while full is dropped without disturbing the queued bytes.
- R4: A frame received on rxd with a high stop bit is queued; status bit0 reads 1 while the receive queue holds data, and a read of word 0 returns the oldest byte in bits 7:0 and removes it.
- R5: A read of word 0 while the receive queue is empty returns 0 and changes nothing.
- R6: Status bit1 reads 1 when the receive queue holds DEPTH bytes; a further complete frame is discarded, sets status bit5 (overrun) and leaves the queued bytes intact.
- R7: A frame whose stop bit samples low is discarded and sets status bit6 (frame error).
- R8: Status bits 5 and 6 stay set until the status word (word 2) is read and read as 0 on the next read; bit7 (parity error) always reads 0 since frames carry no parity.
- R9: In a write to the control word (word 3), bit0 empties the transmit queue, after which status bit2 reads 1, and bit1 empties the receive queue; neither bit is stored and a byte already in the serializer still finishes.
- R10: Status bit4 reads the value of control bit4 last written; writing 0 to the control word clears it.
- R11: With interrupts enabled, irq is high for exactly one clock after the receive queue goes from empty to holding data; with interrupts disabled it stays low.
- R12: With interrupts enabled, irq is high for one clock after the serializer takes the last byte from the transmit queue; with interrupts disabled it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busSel | input | 2 | Word index in the window (byte address bits 3:2): 0 receive, 1 transmit, 2 status, 3 control |
| busWr | input | 1 | Write strobe, one clock per access |
| busRd | input | 1 | Read strobe, one clock per access |
| busWdata | input | 8 | Write data, low byte lane |
| busRdata | output | 32 | Read data, valid in the cycle busRd is high |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench fills the transmit queue past its depth while the serializer drains it, so a design that counts the serializer's byte as a queue slot, or accepts the extra write, sends the wrong number of frames. It overfills the receive queue, where a design that overwrites the newest entry instead of dropping the frame returns corrupted data and a missing overrun flag; it sends a bad stop bit to catch receivers that keep the byte or miss the error. It reads the status twice after each error to catch flags that never clear or clear too early, and it watches irq on every clock so that a level-held or repeated pulse, or one given while disabled, shows up. Queue resets are checked against the serializer, which must finish its current byte but send nothing more.

// File: rtl/lu_pkg.sv
package lu_pkg;

  typedef enum logic [1:0] {
    SEL_RX   = 2'd0,
    SEL_TX   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } lu_sel_e;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
  } lu_strobe_t;

  // state and events from the datapath to the control side
  typedef struct packed {
    logic [7:0] rxHead;
    logic       rxValid;
    logic       rxFull;
    logic       txEmpty;
    logic       txFull;
    logic       ovrEv;
    logic       frmEv;
    logic       rxFirst;
    logic       txDrain;
  } lu_event_t;

endpackage

// File: rtl/lu_fifo.sv
module lu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;

  logic doPush, doPop;
  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign dout  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lu_datapath.sv
module lu_datapath
  import lu_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int OVS_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  lu_strobe_t stb,
  input  logic [7:0] txByte,
  input  logic       rxd,
  output lu_event_t  evt,
  output logic       txd
);
  localparam int DIV_W = $clog2(OVS_DIV + 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI} rx_state_e;

  // oversample tick
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt == DIV_W'(OVS_DIV - 1));
  always_ff @(posedge clk) begin
    if (!rst_n || tick) divCnt <= '0;
    else                divCnt <= divCnt + 1'b1;
  end

  // queues
  logic [7:0] txHead, rxHead;
  logic txEmpty, txFull, rxEmpty, rxFull, txPop, rxDone;
  logic [7:0] rxShift;

  lu_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(stb.txClr), .push(stb.txPush), .din(txByte),
    .pop(txPop), .dout(txHead), .empty(txEmpty), .full(txFull));

  lu_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(stb.rxClr), .push(rxDone), .din(rxShift),
    .pop(stb.rxPop), .dout(rxHead), .empty(rxEmpty), .full(rxFull));

  // transmit serializer
  logic       txBusy;
  logic [3:0] txTickCnt, txBitIdx;
  logic [9:0] txShift;
  assign txPop = !txBusy && !txEmpty;
  assign txd   = txBusy ? txShift[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txBusy <= 1'b0; txTickCnt <= '0; txBitIdx <= '0; txShift <= '1;
    end else if (txPop) begin
      txBusy <= 1'b1; txTickCnt <= '0; txBitIdx <= '0;
      txShift <= {1'b1, txHead, 1'b0};
    end else if (txBusy && tick) begin
      txTickCnt <= txTickCnt + 1'b1;
      if (txTickCnt == 4'd15) begin
        txShift  <= {1'b1, txShift[9:1]};
        txBitIdx <= txBitIdx + 1'b1;
        if (txBitIdx == 4'd9) txBusy <= 1'b0;
      end
    end
  end

  // receive deserializer
  logic rxS1, rxS2, frmEv, ovrEv;
  rx_state_e  rxState;
  logic [3:0] rxTickCnt;
  logic [2:0] rxBitCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxS1 <= 1'b1; rxS2 <= 1'b1;
      rxState <= RX_IDLE; rxTickCnt <= '0; rxBitCnt <= '0; rxShift <= '0;
      rxDone <= 1'b0; frmEv <= 1'b0; ovrEv <= 1'b0;
    end else begin
      rxS1   <= rxd;
      rxS2   <= rxS1;
      rxDone <= 1'b0;
      frmEv  <= 1'b0;
      ovrEv  <= rxDone && rxFull;
      case (rxState)
        RX_IDLE: if (!rxS2) begin rxState <= RX_START; rxTickCnt <= '0; end
        RX_START: if (tick) begin
          if (rxTickCnt == 4'd7) begin
            rxTickCnt <= '0; rxBitCnt <= '0;
            rxState <= rxS2 ? RX_IDLE : RX_DATA;
          end else rxTickCnt <= rxTickCnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          rxTickCnt <= rxTickCnt + 1'b1;
          if (rxTickCnt == 4'd15) begin
            rxShift  <= {rxS2, rxShift[7:1]};
            rxBitCnt <= rxBitCnt + 1'b1;
            if (rxBitCnt == 3'd7) rxState <= RX_STOP;
          end
        end
        RX_STOP: if (tick) begin
          rxTickCnt <= rxTickCnt + 1'b1;
          if (rxTickCnt == 4'd15) begin
            if (rxS2) begin rxDone <= 1'b1; rxState <= RX_IDLE; end
            else      begin frmEv  <= 1'b1; rxState <= RX_WAITHI; end
          end
        end
        default: if (rxS2) rxState <= RX_IDLE;
      endcase
    end
  end

  // edge events on queue occupancy
  logic txEmptyQ, txClrQ, rxEmptyQ;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txEmptyQ <= 1'b1; txClrQ <= 1'b0; rxEmptyQ <= 1'b1;
    end else begin
      txEmptyQ <= txEmpty; txClrQ <= stb.txClr; rxEmptyQ <= rxEmpty;
    end
  end

  assign evt.rxHead  = rxHead;
  assign evt.rxValid = !rxEmpty;
  assign evt.rxFull  = rxFull;
  assign evt.txEmpty = txEmpty;
  assign evt.txFull  = txFull;
  assign evt.ovrEv   = ovrEv;
  assign evt.frmEv   = frmEv;
  assign evt.rxFirst = rxEmptyQ && !rxEmpty;
  assign evt.txDrain = !txEmptyQ && txEmpty && !txClrQ;
endmodule

// File: rtl/lu_ctrl.sv
module lu_ctrl
  import lu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  busSel,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busWdata,
  input  lu_event_t   evt,
  output lu_strobe_t  stb,
  output logic [31:0] busRdata,
  output logic        irq
);
  logic ie, ovrSticky, frmSticky, errClr, ctrlWr;
  logic [7:0] status;

  assign ctrlWr     = busWr && (busSel == SEL_CTRL);
  assign errClr     = busRd && (busSel == SEL_STAT);
  assign stb.txPush = busWr && (busSel == SEL_TX);
  assign stb.rxPop  = busRd && (busSel == SEL_RX);
  assign stb.txClr  = ctrlWr && busWdata[0];
  assign stb.rxClr  = ctrlWr && busWdata[1];

  assign status = {1'b0, frmSticky, ovrSticky, ie,
                   evt.txFull, evt.txEmpty, evt.rxFull, evt.rxValid};

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busSel)
        SEL_RX:   if (evt.rxValid) busRdata[7:0] = evt.rxHead;
        SEL_STAT: busRdata[7:0] = status;
        default:  busRdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie <= 1'b0; ovrSticky <= 1'b0; frmSticky <= 1'b0; irq <= 1'b0;
    end else begin
      if (ctrlWr) ie <= busWdata[4];
      ovrSticky <= evt.ovrEv || (ovrSticky && !errClr);
      frmSticky <= evt.frmEv || (frmSticky && !errClr);
      irq <= ie && (evt.rxFirst || evt.txDrain);
    end
  end
endmodule

// File: rtl/lu_uart.sv
module lu_uart
  import lu_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int OVS_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  busSel,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busWdata,
  output logic [31:0] busRdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  lu_strobe_t stb;
  lu_event_t  evt;

  lu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .evt(evt), .stb(stb), .busRdata(busRdata), .irq(irq));

  lu_datapath #(.DEPTH(DEPTH), .OVS_DIV(OVS_DIV)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .txByte(busWdata), .rxd(rxd),
    .evt(evt), .txd(txd));
endmodule

// File: rtl/lu_uart_chk.sv
module lu_uart_chk
  import lu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  busSel,
  input logic        busRd,
  input logic [31:0] busRdata,
  input logic        irq,
  input lu_strobe_t  stb,
  input lu_event_t   evt
);
  // R5
  rd_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busRd && busSel == SEL_RX && !evt.rxValid) |-> (busRdata == 32'd0));

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt.rxFirst || evt.txDrain));

  // R9
  tx_clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.txClr |=> evt.txEmpty);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.txFull && stb.txPush && !stb.txClr) |=> evt.txFull);
endmodule

bind lu_uart lu_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busSel(busSel), .busRd(busRd),
  .busRdata(busRdata), .irq(irq), .stb(stb), .evt(evt));

// File: tb/lu_uart_bench.sv
module lu_uart_bench;
  localparam int OVS_DIV = 2;
  localparam int BIT = 16 * OVS_DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] busSel = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [31:0] busRdata;
  logic rxd = 1'b1;
  logic txd, irq;

  int nChecks = 0, nFails = 0;
  int irqCount = 0, irqRun = 0, irqMaxRun = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lu_uart #(.DEPTH(16), .OVS_DIV(OVS_DIV)) u_lu_uart (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxd(rxd), .txd(txd), .irq(irq));

  // per-clock observation of the interrupt line
  always @(negedge clk) begin
    if (rst_n && irq) begin
      irqRun++;
      if (irqRun == 1) irqCount++;
      if (irqRun > irqMaxRun) irqMaxRun = irqRun;
    end else irqRun = 0;
  end

  task automatic check(string tag, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] sel, logic [7:0] d);
    @(negedge clk); busSel = sel; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(logic [1:0] sel, output int d);
    @(negedge clk); busSel = sel; busRd = 1'b1;
    #1 d = int'(busRdata);
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic sendRx(logic [7:0] b, logic stopVal);
    @(negedge clk); rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stopVal;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    if (!stopVal) repeat (BIT) @(negedge clk);
  endtask

  task automatic captureTx(output logic [7:0] b, output logic stopBit);
    @(negedge clk);
    while (txd) @(negedge clk);
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      b[i] = txd;
    end
    repeat (BIT) @(negedge clk);
    stopBit = txd;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      summary();
      $finish;
    end
  end

  initial begin
    int d, c0;
    logic [7:0] b;
    logic sb;
    logic [7:0] rxModel[$];
    logic [7:0] txModel[$];

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    check("R1 txd", int'(txd), 1);
    busRead(2'd2, d); check("R1 status", d, 32'h04);

    // R10 enable echo
    busWrite(2'd3, 8'h10);
    busRead(2'd2, d); check("R10 ie echo", d, 32'h14);

    // R2 / R12 single byte out with interrupts on
    c0 = irqCount;
    fork
      busWrite(2'd1, 8'hA5);
      captureTx(b, sb);
    join
    check("R2 tx byte", int'(b), 32'hA5);
    check("R2 stop bit", int'(sb), 1);
    check("R12 drain irq", irqCount - c0, 1);
    repeat (BIT) @(negedge clk);
    check("R2 idle high", int'(txd), 1);

    // R4 / R11 receive one byte
    c0 = irqCount;
    sendRx(8'h3C, 1'b1);
    repeat (4) @(negedge clk);
    check("R11 rx irq", irqCount - c0, 1);
    check("R11 pulse width", irqMaxRun, 1);
    busRead(2'd2, d); check("R4 status valid", d, 32'h15);
    busRead(2'd0, d); check("R4 rx data", d, 32'h3C);
    busRead(2'd2, d); check("R4 status after pop", d, 32'h14);
    // R5 empty read
    busRead(2'd0, d); check("R5 empty read", d, 0);
    busRead(2'd2, d); check("R5 status unchanged", d, 32'h14);

    // R10 disable; R6 overrun with irq off
    busWrite(2'd3, 8'h00);
    busRead(2'd2, d); check("R10 ie cleared", d, 32'h04);
    c0 = irqCount;
    for (int i = 0; i < 17; i++) begin
      b = 8'(i * 7 + 1);
      if (i < 16) rxModel.push_back(b);
      sendRx(b, 1'b1);
    end
    repeat (4) @(negedge clk);
    check("R11 no irq when off", irqCount - c0, 0);
    busRead(2'd2, d); check("R6 full+overrun", d, 32'h27);
    busRead(2'd2, d); check("R8 overrun cleared", d, 32'h07);
    for (int i = 0; i < 16; i++) begin
      busRead(2'd0, d); check("R6 kept data", d, int'(rxModel.pop_front()));
    end
    busRead(2'd2, d); check("R6 drained", d, 32'h04);

    // R7 frame error
    sendRx(8'h55, 1'b0);
    busRead(2'd2, d); check("R7 frame flag", d, 32'h44);
    busRead(2'd2, d); check("R8 frame cleared", d, 32'h04);
    busRead(2'd0, d); check("R7 byte dropped", d, 0);

    // R9 receive queue reset
    sendRx(8'h11, 1'b1);
    sendRx(8'h22, 1'b1);
    busRead(2'd2, d); check("R9 rx before clr", d, 32'h05);
    busWrite(2'd3, 8'h02);
    busRead(2'd2, d); check("R9 rx cleared", d, 32'h04);
    busRead(2'd0, d); check("R9 rx empty read", d, 0);

    // R3 transmit overflow, R12 no irq when off
    c0 = irqCount;
    for (int i = 0; i < 17; i++) txModel.push_back(8'(8'h40 + i));
    fork
      begin
        for (int i = 0; i < 18; i++) busWrite(2'd1, 8'(8'h40 + i));
        busRead(2'd2, d); check("R3 tx full", d, 32'h08);
      end
      begin
        for (int i = 0; i < 17; i++) begin
          captureTx(b, sb);
          check("R3 tx order", int'(b), int'(txModel.pop_front()));
        end
      end
    join
    repeat (2 * 10 * BIT) @(negedge clk);
    check("R3 extra write dropped", int'(txd), 1);
    check("R12 no irq when off", irqCount - c0, 0);
    busRead(2'd2, d); check("R3 empty after", d, 32'h04);

    // R9 transmit queue reset: only the byte in the serializer goes out
    fork
      begin
        for (int i = 0; i < 5; i++) busWrite(2'd1, 8'(8'h90 + i));
        busWrite(2'd3, 8'h01);
        busRead(2'd2, d); check("R9 tx cleared", d, 32'h04);
      end
      captureTx(b, sb);
    join
    check("R9 serializer finished", int'(b), 32'h90);
    begin
      int lows = 0;
      repeat (3 * 10 * BIT) begin
        @(negedge clk);
        if (!txd) lows++;
      end
      check("R9 nothing more sent", lows, 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule